// File: doc/BRIEF.md
# Half-Duty Grid and Segment Timing Generator

This block sequences a vacuum fluorescent display that is multiplexed between two grids. It divides the oscillator clock into bit times and splits every frame into two equal slots: grid 1 owns the first slot and grid 2 the second. Within each slot it opens a segment window, switches the slot's grid on for the requested on-time, then closes the window and leaves the rest of the slot dark. While a slot is active, the 30 segment outputs carry the half of the 60 latched display bits that belongs to that grid.

The on-time comes from one of two sources. In digital dimming mode it is an 11-bit code, with a bit time of 2 clocks and a frame of 4096 bit times. In PWM conversion mode it is an already converted on-time, with a bit time of 4 clocks and a frame of 2048 bit times. A daylight input forces the on-time to the mode's maximum. A low blanking input forces every output low. The mode and the on-time are sampled only at frame boundaries.

The slot sequencer has four states. GAP has everything off. LEAD has the segment window open but the grid off. GRID has both the grid and the window on. LAG has the window on after the grid has turned off. The transitions are as follows:
- At each slot end the sequencer goes to LEAD, or to GAP when the on-time is zero.
- LEAD goes to GRID after 3 bit times.
- GRID goes to LAG after the on-time, or straight to GAP when the mode's lag is zero.
- LAG goes to GAP after its lag.
- GAP holds until the slot ends.

Top module: `halfduty_grid_timer`

## Requirements
- R1: During reset and after it, all grid and segment outputs are low until a frame boundary loads a nonzero on-time. The reset mode is PWM conversion with an on-time of zero.
- R2: With `dig_mode`=1, a bit time is 2 clocks and a frame is 8192 clocks. Each grid is high for `dim_code`×2 clocks once per frame.
- R3: In digital mode, a code above 2032 gives an on-time of exactly 2032 bit times (4064 clocks).
- R4: The segment window opens 3 bit times before its grid rises. In digital mode it closes 3 bit times after the grid falls, so the window is the on-time + 6 bit times. In PWM mode it closes with the grid, so the window is the on-time + 3 bit times.
- R5: With `dig_mode`=0, a bit time is 4 clocks and a frame is 8192 clocks. Each grid is high for min(`pwm_on`, 256)×4 clocks per frame.
- R6: With `daylight`=1, the on-time is the mode maximum (2032 or 256) whatever the dimming value.
- R7: While grid 1 is high, `seg` equals `disp_bits[29:0]`, so `seg[0]` carries display bit 1. While grid 2 is high, `seg` equals `disp_bits[59:30]`. The two grids are never high together.
- R8: One clock after `blank_n` goes low, `grid1`, `grid2` and `seg` are all zero, and they stay zero while it is low. Normal output resumes after `blank_n` returns high.
- R9: A change of on-time or mode made during a frame has no effect until the next frame. The grid pulse in progress and the grid 2 pulse of the same frame keep the old length.
- R10: An on-time of zero produces no grid pulse and no segment window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dig_mode | input | 1 | 1 = digital dimming, 0 = PWM conversion |
| dim_code | input | 11 | Digital dimming on-time in bit times |
| pwm_on | input | 9 | Converted PWM on-time in bit times |
| daylight | input | 1 | 1 forces the maximum on-time |
| blank_n | input | 1 | 0 forces all outputs low |
| disp_bits | input | 60 | Latched display bits; bits 29:0 go with grid 1, bits 59:30 with grid 2 |
| grid1 | output | 1 | Grid 1 enable |
| grid2 | output | 1 | Grid 2 enable |
| seg | output | 30 | Segment enables |

## Verification
A new dimming setting takes effect only at the next frame boundary, which comes at most 8192 clocks later. Each directed task therefore waits 8200 clocks before it counts pulse and window lengths over an exact 8192-clock window. Because the output pattern repeats every frame, those counts do not depend on where the window starts.

The lead and lag distances are measured in clocks between observed output edges, and compared with 3 bit times and with the mode's lag. Blanking is registered once, so the zero outputs are sampled from the first falling clock edge after `blank_n` drops. For R9 the bench synchronises to a grid 1 rising edge and then changes the code at once. It expects the old length for that frame's two pulses and the new length for the next grid 1 pulse.

// File: rtl/hd_pkg.sv
package hd_pkg;
    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,
        ST_LEAD = 2'd1,
        ST_GRID = 2'd2,
        ST_LAG  = 2'd3
    } slot_state_e;
endpackage

// File: rtl/hd_bit_timer.sv
module hd_bit_timer #(
    parameter int DIG_CLKS_PER_BIT = 2,
    parameter int PWM_CLKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_dig,
    output logic bit_tick
);
    localparam int DIV_MAX = (DIG_CLKS_PER_BIT > PWM_CLKS_PER_BIT) ? DIG_CLKS_PER_BIT : PWM_CLKS_PER_BIT;
    localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [CNT_W-1:0] DIG_LAST = CNT_W'(DIG_CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] PWM_LAST = CNT_W'(PWM_CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] div_cnt;

    assign bit_tick = (div_cnt == (mode_dig ? DIG_LAST : PWM_LAST));

    always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (bit_tick) div_cnt <= '0;
        else               div_cnt <= div_cnt + 1'b1;
    end

    // R2/R5: a bit time is at least two clocks, so ticks never come back to back
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

// File: rtl/hd_dim_select.sv
module hd_dim_select #(
    parameter int DIM_W       = 11,
    parameter int PWM_W       = 9,
    parameter int DIG_MAX_ON  = 2032,
    parameter int PWM_MAX_ON  = 256,
    parameter int DIG_SEG_LAG = 3,
    parameter int PWM_SEG_LAG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dig_mode,
    input  logic [DIM_W-1:0] dim_code,
    input  logic [PWM_W-1:0] pwm_on,
    input  logic             daylight,
    input  logic             frame_end,
    output logic             mode_cur,
    output logic [DIM_W-1:0] on_cur,
    output logic [DIM_W-1:0] on_start,
    output logic [DIM_W-1:0] lag_cur
);
    localparam logic [DIM_W-1:0] DIG_CAP  = DIM_W'(DIG_MAX_ON);
    localparam logic [DIM_W-1:0] PWM_CAP  = DIM_W'(PWM_MAX_ON);
    localparam logic [DIM_W-1:0] DIG_LAGV = DIM_W'(DIG_SEG_LAG);
    localparam logic [DIM_W-1:0] PWM_LAGV = DIM_W'(PWM_SEG_LAG);

    logic [DIM_W-1:0] src_on;
    logic [DIM_W-1:0] cap_on;
    logic [DIM_W-1:0] on_new;

    always_comb begin
        src_on   = dig_mode ? dim_code : DIM_W'(pwm_on);
        cap_on   = dig_mode ? DIG_CAP : PWM_CAP;
        if (daylight)            on_new = cap_on;
        else if (src_on > cap_on) on_new = cap_on;
        else                     on_new = src_on;
        on_start = frame_end ? on_new : on_cur;
        lag_cur  = mode_cur ? DIG_LAGV : PWM_LAGV;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cur <= 1'b0;
            on_cur   <= '0;
        end else if (frame_end) begin
            mode_cur <= dig_mode;
            on_cur   <= on_new;
        end
    end

    // R9: configuration holds between frame boundaries
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(on_cur) && $stable(mode_cur)));

    // R3: the held on-time never exceeds the cap of its mode
    p_on_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur ? (on_cur <= DIG_CAP) : (on_cur <= PWM_CAP)));
endmodule

// File: rtl/hd_slot_fsm.sv
module hd_slot_fsm
    import hd_pkg::*;
#(
    parameter int DIM_W         = 11,
    parameter int DIG_SLOT_BITS = 2048,
    parameter int PWM_SLOT_BITS = 1024,
    parameter int SEG_LEAD      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             mode_dig,
    input  logic [DIM_W-1:0] on_cur,
    input  logic [DIM_W-1:0] on_start,
    input  logic [DIM_W-1:0] lag_cur,
    output slot_state_e      state,
    output logic             slot_id,
    output logic             frame_end
);
    localparam int POS_W = $clog2(DIG_SLOT_BITS);
    localparam logic [POS_W-1:0] DIG_LAST = POS_W'(DIG_SLOT_BITS - 1);
    localparam logic [POS_W-1:0] PWM_LAST = POS_W'(PWM_SLOT_BITS - 1);
    localparam logic [DIM_W-1:0] LEAD_M1  = DIM_W'(SEG_LEAD - 1);

    slot_state_e      state_nx;
    logic [DIM_W-1:0] dwell, dwell_nx;
    logic [POS_W-1:0] pos;
    logic             slot_end;

    assign slot_end  = bit_tick && (pos == (mode_dig ? DIG_LAST : PWM_LAST));
    assign frame_end = slot_end && slot_id;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_GAP;
            dwell   <= '0;
            pos     <= '0;
            slot_id <= 1'b0;
        end else begin
            state <= state_nx;
            dwell <= dwell_nx;
            if (bit_tick) begin
                pos     <= slot_end ? '0 : pos + 1'b1;
                slot_id <= slot_end ? ~slot_id : slot_id;
            end
        end
    end

    always_comb begin
        state_nx = state;
        dwell_nx = dwell;
        if (bit_tick) begin
            if (slot_end) begin
                state_nx = (on_start == '0) ? ST_GAP : ST_LEAD;
                dwell_nx = LEAD_M1;
            end else begin
                unique case (state)
                    ST_LEAD: begin
                        if (dwell == '0) begin
                            state_nx = ST_GRID;
                            dwell_nx = on_cur - 1'b1;
                        end else begin
                            dwell_nx = dwell - 1'b1;
                        end
                    end
                    ST_GRID: begin
                        if (dwell == '0) begin
                            if (lag_cur == '0) begin
                                state_nx = ST_GAP;
                            end else begin
                                state_nx = ST_LAG;
                                dwell_nx = lag_cur - 1'b1;
                            end
                        end else begin
                            dwell_nx = dwell - 1'b1;
                        end
                    end
                    ST_LAG: begin
                        if (dwell == '0) state_nx = ST_GAP;
                        else             dwell_nx = dwell - 1'b1;
                    end
                    ST_GAP: begin
                        state_nx = ST_GAP;
                    end
                endcase
            end
        end
    end

    // R4/R10: every slot starts in LEAD or in GAP
    p_slot_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (state == ST_LEAD || state == ST_GAP));

    // R3: the remaining grid time stays below the held on-time
    p_grid_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRID) |-> (dwell < on_cur));
endmodule

// File: rtl/halfduty_grid_timer.sv
module halfduty_grid_timer
    import hd_pkg::*;
#(
    parameter int NSEG             = 30,
    parameter int DIM_W            = 11,
    parameter int PWM_W            = 9,
    parameter int DIG_CLKS_PER_BIT = 2,
    parameter int PWM_CLKS_PER_BIT = 4,
    parameter int DIG_SLOT_BITS    = 2048,
    parameter int PWM_SLOT_BITS    = 1024,
    parameter int DIG_MAX_ON       = 2032,
    parameter int PWM_MAX_ON       = 256,
    parameter int SEG_LEAD         = 3,
    parameter int DIG_SEG_LAG      = 3,
    parameter int PWM_SEG_LAG      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dig_mode,
    input  logic [DIM_W-1:0]  dim_code,
    input  logic [PWM_W-1:0]  pwm_on,
    input  logic              daylight,
    input  logic              blank_n,
    input  logic [2*NSEG-1:0] disp_bits,
    output logic              grid1,
    output logic              grid2,
    output logic [NSEG-1:0]   seg
);
    logic             bit_tick;
    logic             mode_cur;
    logic [DIM_W-1:0] on_cur, on_start, lag_cur;
    slot_state_e      state;
    logic             slot_id;
    logic             frame_end;
    logic             win_on;

    hd_bit_timer #(
        .DIG_CLKS_PER_BIT (DIG_CLKS_PER_BIT),
        .PWM_CLKS_PER_BIT (PWM_CLKS_PER_BIT)
    ) u_bit_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_dig (mode_cur),
        .bit_tick (bit_tick)
    );

    hd_dim_select #(
        .DIM_W       (DIM_W),
        .PWM_W       (PWM_W),
        .DIG_MAX_ON  (DIG_MAX_ON),
        .PWM_MAX_ON  (PWM_MAX_ON),
        .DIG_SEG_LAG (DIG_SEG_LAG),
        .PWM_SEG_LAG (PWM_SEG_LAG)
    ) u_dim_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .dig_mode  (dig_mode),
        .dim_code  (dim_code),
        .pwm_on    (pwm_on),
        .daylight  (daylight),
        .frame_end (frame_end),
        .mode_cur  (mode_cur),
        .on_cur    (on_cur),
        .on_start  (on_start),
        .lag_cur   (lag_cur)
    );

    hd_slot_fsm #(
        .DIM_W         (DIM_W),
        .DIG_SLOT_BITS (DIG_SLOT_BITS),
        .PWM_SLOT_BITS (PWM_SLOT_BITS),
        .SEG_LEAD      (SEG_LEAD)
    ) u_slot_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .mode_dig  (mode_cur),
        .on_cur    (on_cur),
        .on_start  (on_start),
        .lag_cur   (lag_cur),
        .state     (state),
        .slot_id   (slot_id),
        .frame_end (frame_end)
    );

    assign win_on = (state != ST_GAP);

    always_ff @(posedge clk) begin
        if (!rst_n || !blank_n) begin
            grid1 <= 1'b0;
            grid2 <= 1'b0;
            seg   <= '0;
        end else begin
            grid1 <= (state == ST_GRID) && !slot_id;
            grid2 <= (state == ST_GRID) && slot_id;
            if (!win_on)      seg <= '0;
            else if (slot_id) seg <= disp_bits[2*NSEG-1:NSEG];
            else              seg <= disp_bits[NSEG-1:0];
        end
    end

    // R7: the two grids are never driven together
    p_one_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grid1 && grid2));

    // R8: blanking clears every output on the next clock
    p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> (!grid1 && !grid2 && seg == '0));
endmodule

// File: tb/test_halfduty_grid_timer.sv
module test_halfduty_grid_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dig_mode = 1'b0;
    logic [10:0] dim_code = '0;
    logic [8:0]  pwm_on = '0;
    logic        daylight = 1'b0;
    logic        blank_n = 1'b1;
    logic [59:0] disp_bits;
    logic        grid1, grid2;
    logic [29:0] seg;

    localparam logic [29:0] LO_PAT = 30'h2AB5_1234;
    localparam logic [29:0] HI_PAT = 30'h1C3F_0F0F;
    localparam int FRAME_CLKS = 8192;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign disp_bits = {HI_PAT, LO_PAT};

    always #2 clk = ~clk;

    halfduty_grid_timer i_halfduty_grid_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .dig_mode  (dig_mode),
        .dim_code  (dim_code),
        .pwm_on    (pwm_on),
        .daylight  (daylight),
        .blank_n   (blank_n),
        .disp_bits (disp_bits),
        .grid1     (grid1),
        .grid2     (grid2),
        .seg       (seg)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (FRAME_CLKS + 8) @(negedge clk);
    endtask

    // counts over one full frame; the pattern repeats every frame
    task automatic measure(string req, int on_bits, int div, int lag_bits);
        int g1 = 0, g2 = 0, sw = 0, bad = 0;
        int lead_cnt = 0, lead_val = -1, lag_cnt = 0, lag_val = -1;
        bit lead_arm = 0, lag_arm = 0, p_gr = 0, p_sw = 0, gr, s_on;
        for (int i = 0; i < FRAME_CLKS; i++) begin
            @(negedge clk);
            gr   = grid1 | grid2;
            s_on = (seg != '0);
            if (grid1) g1++;
            if (grid2) g2++;
            if (s_on) sw++;
            if (grid1 && seg != LO_PAT) bad++;
            if (grid2 && seg != HI_PAT) bad++;
            if (i > 0 && s_on && !p_sw) begin lead_arm = 1; lead_cnt = 0; end
            if (lead_arm && !gr) lead_cnt++;
            if (lead_arm && gr && !p_gr) begin lead_val = lead_cnt; lead_arm = 0; end
            if (i > 0 && p_gr && !gr) begin lag_arm = 1; lag_cnt = 0; end
            if (lag_arm && s_on) lag_cnt++;
            if (lag_arm && !s_on) begin lag_val = lag_cnt; lag_arm = 0; end
            p_gr = gr;
            p_sw = s_on;
        end
        check_eq(req, "grid1 clocks per frame", g1, on_bits * div);
        check_eq(req, "grid2 clocks per frame", g2, on_bits * div);
        check_eq("R4", "segment window clocks per frame", sw,
                 (on_bits == 0) ? 0 : 2 * (on_bits + 3 + lag_bits) * div);
        check_eq("R7", "segment data mismatches", bad, 0);
        if (on_bits > 0) begin
            check_eq("R4", "lead clocks", lead_val, 3 * div);
            check_eq("R4", "lag clocks", lag_val, lag_bits * div);
        end
    endtask

    task automatic pulse_len(input bit which, output int len);
        len = 0;
        do @(negedge clk); while ((which ? grid2 : grid1) == 1'b0);
        while ((which ? grid2 : grid1) == 1'b1) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int nz = 0;
        repeat (5) @(negedge clk);
        check_eq("R1", "grid1 in reset", grid1, 0);
        check_eq("R1", "seg in reset", seg, 0);
        rst_n = 1'b1;
        dig_mode = 1'b1;
        dim_code = 11'd100;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (grid1 || grid2 || seg != '0) nz++;
        end
        check_eq("R1", "active cycles before first frame boundary", nz, 0);
    endtask

    task automatic t_digital();
        settle();
        measure("R2", 100, 2, 3);
    endtask

    task automatic t_frame_update();
        int len;
        do @(negedge clk); while (grid1 == 1'b0);
        dim_code = 11'd500;
        len = 1;
        while (grid1) begin @(negedge clk); if (grid1) len++; end
        check_eq("R9", "grid1 pulse after mid-frame change", len, 200);
        pulse_len(1'b1, len);
        check_eq("R9", "grid2 pulse same frame", len, 200);
        pulse_len(1'b0, len);
        check_eq("R9", "grid1 pulse next frame", len, 1000);
    endtask

    task automatic t_cap();
        dim_code = 11'd2047;
        settle();
        measure("R3", 2032, 2, 3);
    endtask

    task automatic t_daylight_blank();
        int nz = 0;
        dim_code = 11'd10;
        daylight = 1'b1;
        settle();
        measure("R6", 2032, 2, 3);
        blank_n = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (grid1 || grid2 || seg != '0) nz++;
        end
        check_eq("R8", "active cycles while blanked", nz, 0);
        blank_n = 1'b1;
        @(negedge clk);
        measure("R8", 2032, 2, 3);
        daylight = 1'b0;
    endtask

    task automatic t_pwm();
        dig_mode = 1'b0;
        pwm_on = 9'd50;
        settle();
        measure("R5", 50, 4, 0);
        pwm_on = 9'd300;
        settle();
        measure("R5", 256, 4, 0);
    endtask

    task automatic t_zero();
        dig_mode = 1'b1;
        dim_code = 11'd0;
        settle();
        measure("R10", 0, 2, 3);
    endtask

    initial begin
        t_reset();
        t_digital();
        t_frame_update();
        t_cap();
        t_daylight_blank();
        t_pwm();
        t_zero();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(negedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule